// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

An 8-bit status and control register for a supply-monitor function. It takes the level from a low-voltage comparator, which arrives asynchronously, through a synchroniser. It decides whether detection is currently qualified: the detect enable must be set and, while the chip is in stop mode, the stop enable must also be set. A rising edge of the qualified condition sets a sticky flag. The flag can raise an interrupt request. The qualified condition itself can raise a reset request.

Software reads the whole register in one cycle. It acknowledges the flag by writing 1 to the acknowledge bit. The acknowledge only takes effect once the synchronised comparator no longer reports low voltage. The reset-enable and detect-enable bits accept the first write after reset and then hold that value until the next reset. The bandgap-buffer enable bit drives a dedicated output pin.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset, `rdata_o` reads 8'h1C, and `irq_o`, `rst_req_o` and `bg_buf_en_o` are 0 while the comparator input is inactive.
- R2: Read layout: bit 7 is the flag, bit 5 the interrupt enable, bit 4 the reset enable, bit 3 the stop enable, bit 2 the detect enable and bit 0 the bandgap enable. Bits 6 and 1 always read 0, and writes to bit 7 are ignored. `bg_buf_en_o` equals bit 0.
- R3: The flag sets one cycle after the qualified condition rises and stays set until an acknowledge is accepted. The qualified condition is the synchronised low-voltage level AND detect enable AND (not stop mode OR stop enable). The synchroniser has two stages.
- R4: If `lv_async_i` is already 1 when reset is released, the flag sets three cycles later without any further edge.
- R5: A write with bit 6 = 1 clears the flag only if the synchronised low-voltage level is 0. Otherwise the flag stays 1.
- R6: Bits 4 and 2 take their value from the first write after reset only. Later writes leave them unchanged, while bits 5, 3 and 0 remain writable on every write.
- R7: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R8: `rst_req_o` is 1 while the qualified condition holds and the reset enable is 1. With the reset enable at 0 it stays 0.
- R9: With the detect enable at 0, the comparator causes no flag, no `irq_o` and no `rst_req_o`.
- R10: While `stop_mode_i` is 1 and the stop enable is 0, detection is suppressed. Setting the stop enable re-qualifies detection, and the flag then sets on the resulting rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lv_async_i | input | 1 | Comparator level, 1 = supply below trip point (asynchronous) |
| stop_mode_i | input | 1 | Chip is in stop mode |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |
| bg_buf_en_o | output | 1 | Bandgap buffer enable |

## Verification
Two events can land on the same edge. One is an acknowledge write that arrives while the synchronised comparator still reports low voltage. The other is a single write that touches both the locked enables and the still-writable bits. The bench provokes the first by holding the comparator active through an acknowledge write, then releasing it and acknowledging again. The flag must survive the first write and clear on the second. It provokes the second by writing all-ones data after a locking write of zeros; the read-back must show only bits 5, 3 and 0 changed.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W       = 8;
  localparam int SYNC_STAGES = 2;

  localparam int FLAG_BIT    = 7;
  localparam int ACK_BIT     = 6;
  localparam int IRQ_EN_BIT  = 5;
  localparam int RST_EN_BIT  = 4;
  localparam int STOP_EN_BIT = 3;
  localparam int DET_EN_BIT  = 2;
  localparam int BG_EN_BIT   = 0;

  localparam logic [REG_W-1:0] CTRL_RST  = REG_W'((1 << RST_EN_BIT) | (1 << STOP_EN_BIT) |
                                                  (1 << DET_EN_BIT));
  localparam logic [REG_W-1:0] FREE_MASK = REG_W'((1 << IRQ_EN_BIT) | (1 << STOP_EN_BIT) |
                                                  (1 << BG_EN_BIT));

  localparam int ONCE_N = 2;
  typedef int unsigned once_pos_t [ONCE_N];
  localparam once_pos_t ONCE_POS = '{RST_EN_BIT, DET_EN_BIT};
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lvd_ctrl_bits.sv
module lvd_ctrl_bits
  import lvd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0]  free_q;
  logic [ONCE_N-1:0] once_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      free_q <= CTRL_RST & FREE_MASK;
    else if (wr_en_i) free_q <= wdata_i & FREE_MASK;
  end

  // one value flop and one lock flop per write-once bit
  for (genvar g = 0; g < ONCE_N; g++) begin : g_once
    logic bit_q, lock_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q  <= CTRL_RST[ONCE_POS[g]];
        lock_q <= 1'b0;
      end else if (wr_en_i && !lock_q) begin
        bit_q  <= wdata_i[ONCE_POS[g]];
        lock_q <= 1'b1;
      end
    end
    assign once_bits[g] = bit_q;
  end

  always_comb begin
    ctrl_o = free_q;
    for (int i = 0; i < ONCE_N; i++) ctrl_o[ONCE_POS[i]] = once_bits[i];
  end
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lv_s_i,
  input  logic det_en_i,
  input  logic stop_en_i,
  input  logic stop_mode_i,
  input  logic ack_wr_i,
  output logic flag_o,
  output logic active_o
);
  logic active, active_q, set_evt, clr_ok, flag_q;

  assign active  = lv_s_i & det_en_i & (~stop_mode_i | stop_en_i);
  assign set_evt = active & ~active_q;
  // acknowledge only honoured once the low-voltage level is gone
  assign clr_ok  = ack_wr_i & ~lv_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      active_q <= active;
      flag_q   <= set_evt | (flag_q & ~clr_ok);
    end
  end

  assign flag_o   = flag_q;
  assign active_o = active;
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lv_async_i,
  input  logic             stop_mode_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             bg_buf_en_o
);
  logic             lv_s;
  logic [REG_W-1:0] ctrl;
  logic             flag, active;

  lvd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lv_async_i),
    .q_o   (lv_s)
  );

  lvd_ctrl_bits i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl)
  );

  lvd_flag i_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lv_s_i     (lv_s),
    .det_en_i   (ctrl[DET_EN_BIT]),
    .stop_en_i  (ctrl[STOP_EN_BIT]),
    .stop_mode_i(stop_mode_i),
    .ack_wr_i   (wr_en_i & wdata_i[ACK_BIT]),
    .flag_o     (flag),
    .active_o   (active)
  );

  always_comb begin
    rdata_o           = ctrl;
    rdata_o[FLAG_BIT] = flag;
  end

  assign irq_o       = flag & ctrl[IRQ_EN_BIT];
  assign rst_req_o   = active & ctrl[RST_EN_BIT];
  assign bg_buf_en_o = ctrl[BG_EN_BIT];
endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_mode_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       bg_buf_en_o,
  input logic       lv_s_i
);
  logic seen_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_wr_q <= 1'b0;
    else if (wr_en_i) seen_wr_q <= 1'b1;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6] == 1'b0 && rdata_o[1] == 1'b0 && bg_buf_en_o == rdata_o[0]);

  assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] && !(wr_en_i && wdata_i[6]) |=> rdata_o[7]);

  assert_ack_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wdata_i[6] && lv_s_i && rdata_o[7] |=> rdata_o[7]);

  assert_lock_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_wr_q && wr_en_i |=> $stable(rdata_o[4]) && $stable(rdata_o[2]));

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o[7] && rdata_o[5]));

  assert_no_rst_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[2] |-> !rst_req_o);

  assert_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[2] && !rdata_o[7] |=> !rdata_o[7]);

  assert_stop_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mode_i && !rdata_o[3] |-> !rst_req_o);
endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_mode_i(stop_mode_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o),
  .bg_buf_en_o(bg_buf_en_o),
  .lv_s_i     (lv_s)
);

// File: tb/test_lvd_ctrl_reg.sv
module test_lvd_ctrl_reg;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lv = 1'b0;
  logic       stop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, rst_req, bg;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lvd_ctrl_reg i_lvd_ctrl_reg (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .lv_async_i (lv),
    .stop_mode_i(stop),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_o      (irq),
    .rst_req_o  (rst_req),
    .bg_buf_en_o(bg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic lv_level);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wdata = 8'h00; stop = 1'b0; lv = lv_level;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d;
    step(1);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    step(3);
    chk("R1 rdata", rdata, 8'h1C);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rst_req", {7'd0, rst_req}, 8'h00);
    chk("R1 bg", {7'd0, bg}, 8'h00);
  endtask

  task automatic t_flag_ack;
    do_reset(1'b0);
    wr(8'h34);
    chk("R6 first write", rdata, 8'h34);
    lv = 1'b1;
    step(2);
    chk("R8 rst_req on", {7'd0, rst_req}, 8'h01);
    chk("R3 flag not yet", rdata, 8'h34);
    step(1);
    chk("R3 flag set", rdata, 8'hB4);
    chk("R7 irq on", {7'd0, irq}, 8'h01);
    wr(8'h74);
    chk("R5 ack while low", rdata, 8'hB4);
    lv = 1'b0;
    step(2);
    chk("R8 rst_req off", {7'd0, rst_req}, 8'h00);
    chk("R3 flag sticky", rdata, 8'hB4);
    wr(8'h14);
    chk("R7 irq masked", {7'd0, irq}, 8'h00);
    chk("R7 rdata", rdata, 8'h94);
    wr(8'h74);
    chk("R5 ack clears", rdata, 8'h34);
    chk("R7 irq off", {7'd0, irq}, 8'h00);
    lv = 1'b1;
    step(3);
    chk("R3 retrigger", rdata, 8'hB4);
    lv = 1'b0;
  endtask

  task automatic t_lock;
    do_reset(1'b0);
    wr(8'h00);
    chk("R6 lock zero", rdata, 8'h00);
    wr(8'h3D);
    chk("R6 locked bits held", rdata, 8'h29);
    chk("R2 bg pin", {7'd0, bg}, 8'h01);
    lv = 1'b1;
    step(4);
    chk("R9 no flag", rdata, 8'h29);
    chk("R9 no rst_req", {7'd0, rst_req}, 8'h00);
    chk("R9 no irq", {7'd0, irq}, 8'h00);
    wr(8'hFF);
    chk("R2 fixed bits", rdata, 8'h29);
    lv = 1'b0;
  endtask

  task automatic t_no_reset_req;
    do_reset(1'b0);
    wr(8'h24);
    lv = 1'b1;
    step(3);
    chk("R8 flag", rdata, 8'hA4);
    chk("R8 rst_req gated", {7'd0, rst_req}, 8'h00);
    lv = 1'b0;
  endtask

  task automatic t_stop;
    do_reset(1'b0);
    wr(8'h14);
    stop = 1'b1;
    lv = 1'b1;
    step(4);
    chk("R10 suppressed flag", rdata, 8'h14);
    chk("R10 suppressed rst_req", {7'd0, rst_req}, 8'h00);
    wr(8'h1C);
    chk("R10 rst_req", {7'd0, rst_req}, 8'h01);
    step(1);
    chk("R10 flag", rdata, 8'h9C);
    stop = 1'b0;
    lv = 1'b0;
  endtask

  task automatic t_preexisting;
    do_reset(1'b1);
    step(2);
    chk("R4 rst_req", {7'd0, rst_req}, 8'h01);
    chk("R4 flag pending", rdata, 8'h1C);
    step(1);
    chk("R4 flag", rdata, 8'h9C);
    chk("R4 irq off", {7'd0, irq}, 8'h00);
    lv = 1'b0;
  endtask

  initial begin
    step(1);
    t_reset_state();
    t_flag_ack();
    t_lock();
    t_no_reset_req();
    t_stop();
    t_preexisting();
    step(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule